// File: doc/BRIEF.md
# Page Table Walker for TLB Refill

This block services one translation miss at a time by reading a single-level page table in main memory. When the translation buffer misses, it hands over the missing virtual page number, the current table base address and whether the faulting access was a store. The walker forms the entry address as base plus four times the page number. It issues one word read and waits as long as memory needs to answer.

The returned 32-bit entry is then judged. Bit 31 marks the page as resident, bit 30 is the dirty flag, bit 29 the referenced flag, bit 28 grants store permission, and bits 17..0 carry the physical page number. A non-resident page becomes a page-fault pulse and no refill. A resident page becomes a one-cycle refill pulse carrying the page number, the physical page and the store permission, after which the original access can be replayed. If the referenced flag is clear, or the access is a store and the dirty flag is clear, the walker first writes the entry back with those flags set. That write finishes before the refill pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `busy`, `mem_req`, `refill_valid` and `fault` are all low.
- R2: A start request seen while idle raises `busy` on the next cycle. In that same first busy cycle the walker issues a single read (`mem_req`=1, `mem_we`=0) at `mem_addr` = `pt_base` + 4 × `miss_vpn`, using the values held at the start.
- R3: The walker waits any number of cycles for `mem_rvalid` and issues no further read during the wait. `mem_rdata` is taken only in a cycle with `mem_rvalid` high, after the read was issued.
- R4: A resident entry (bit 31 = 1) that needs no write-back gives exactly one `refill_valid` pulse, two cycles after the `mem_rvalid` cycle. The pulse carries `refill_vpn` = the walked page number and `refill_ppn` = entry bits 17..0, and no memory write occurs.
- R5: A resident entry with the referenced flag (bit 29) clear is written back once, to the same address, with bit 29 set and all other bits unchanged. That write precedes the refill pulse by one cycle, so the refill comes three cycles after `mem_rvalid`.
- R6: On a store miss (`miss_write` = 1), a resident entry with the dirty flag (bit 30) clear is written back with both bit 30 and bit 29 set. A store miss whose entry already has both flags set causes no write.
- R7: A non-resident entry (bit 31 = 0) gives exactly one `fault` pulse two cycles after `mem_rvalid`, with `fault_vpn` = the walked page number. It causes no refill and no memory write, whatever the other bits hold.
- R8: A start request that arrives while `busy` is high is ignored. No second read is issued, the refill reports the first page number, and the walker returns to idle afterwards.
- R9: `busy` stays high from the read cycle through the refill or fault cycle and drops on the cycle after. A walk with N wait cycles before `mem_rvalid` therefore holds `busy` for N+4 cycles, or N+5 cycles with a write-back.
- R10: `refill_writable` equals entry bit 28 during the refill pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_start | input | 1 | Start a walk (honoured only when idle) |
| miss_vpn | input | VPN_W (20) | Virtual page number that missed |
| miss_write | input | 1 | The missing access was a store |
| pt_base | input | ADDR_W (32) | Page table base address |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | ADDR_W (32) | Entry byte address |
| mem_wdata | output | 32 | Updated entry for the write-back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Returned page table entry |
| refill_valid | output | 1 | One-cycle refill pulse toward the translation buffer |
| refill_vpn | output | VPN_W (20) | Page number being refilled |
| refill_ppn | output | PPN_W (18) | Physical page number from the entry |
| refill_writable | output | 1 | Store permission from the entry |
| fault | output | 1 | One-cycle page-fault pulse |
| fault_vpn | output | VPN_W (20) | Page number that faulted |

## Verification
The properties assume that memory raises `mem_rvalid` only for a read the walker has issued, and only in a cycle after that read. They also assume a write is accepted in the cycle it is presented, with no back-pressure. The bench memory model follows both rules. It answers each read exactly once after a programmable delay of zero or more cycles, and drives junk data outside the valid cycle. Start requests come only on falling edges, and the stray start used for the busy case lands while a read is outstanding.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int PTE_W   = 32;
  localparam int VLD_POS = 31;
  localparam int DRT_POS = 30;
  localparam int REF_POS = 29;
  localparam int WRP_POS = 28;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RREQ   = 3'd1,
    S_RWAIT  = 3'd2,
    S_CHECK  = 3'd3,
    S_WBACK  = 3'd4,
    S_REFILL = 3'd5,
    S_FAULT  = 3'd6
  } walk_state_t;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int VPN_W  = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] addr
);

  localparam int ENTRY_SHIFT = 2;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = ADDR_W'(vpn) << ENTRY_SHIFT;
    addr   = base + offset;
  end

endmodule

// File: rtl/pt_pte_eval.sv
module pt_pte_eval
  import pt_walker_pkg::*;
#(
  parameter int PPN_W = 18
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  output logic             present,
  output logic [PPN_W-1:0] ppn,
  output logic             writable,
  output logic             need_wb,
  output logic [PTE_W-1:0] wb_word
);

  localparam logic [PTE_W-1:0] REF_MASK = PTE_W'(1) << REF_POS;
  localparam logic [PTE_W-1:0] DRT_MASK = PTE_W'(1) << DRT_POS;

  always_comb begin
    present  = pte[VLD_POS];
    ppn      = pte[PPN_W-1:0];
    writable = pte[WRP_POS];
    need_wb  = present && (!pte[REF_POS] || (is_write && !pte[DRT_POS]));
    wb_word  = pte | REF_MASK | (is_write ? DRT_MASK : '0);
  end

  // R6
  always_comb begin
    if (need_wb && is_write) begin
      store_marks_dirty_chk: assert (wb_word[DRT_POS] && wb_word[REF_POS]);
    end
  end

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rvalid,
  input  logic        present,
  input  logic        need_wb,
  output walk_state_t state_q,
  output logic        cap_req,
  output logic        cap_pte
);

  walk_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start) state_d = S_RREQ;
      S_RREQ:   state_d = S_RWAIT;
      S_RWAIT:  if (rvalid) state_d = S_CHECK;
      S_CHECK: begin
        if (!present)     state_d = S_FAULT;
        else if (need_wb) state_d = S_WBACK;
        else              state_d = S_REFILL;
      end
      S_WBACK:  state_d = S_REFILL;
      S_REFILL: state_d = S_IDLE;
      S_FAULT:  state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_comb begin
    cap_req = (state_q == S_IDLE) && start;
    cap_pte = (state_q == S_RWAIT) && rvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RWAIT && !rvalid) |=> (state_q == S_RWAIT));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_start,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic              miss_write,
  input  logic [ADDR_W-1:0] pt_base,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PTE_W-1:0]  mem_wdata,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              refill_valid,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic [PPN_W-1:0]  refill_ppn,
  output logic              refill_writable,
  output logic              fault,
  output logic [VPN_W-1:0]  fault_vpn
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  walk_state_t       state_q;
  logic              cap_req, cap_pte;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic              wr_q;
  logic [PTE_W-1:0]  pte_q;
  logic              present, need_wb, writable;
  logic [PPN_W-1:0]  ppn;
  logic [PTE_W-1:0]  wb_word;
  logic [ADDR_W-1:0] entry_addr;

  pt_walk_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (miss_start),
    .rvalid  (mem_rvalid),
    .present (present),
    .need_wb (need_wb),
    .state_q (state_q),
    .cap_req (cap_req),
    .cap_pte (cap_pte)
  );

  always_ff @(posedge clk) begin
    if (cap_req) begin
      vpn_q  <= miss_vpn;
      base_q <= pt_base;
      wr_q   <= miss_write;
    end
    if (cap_pte) pte_q <= mem_rdata;
  end

  pt_addr_gen #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) u_addr (
    .base (base_q),
    .vpn  (vpn_q),
    .addr (entry_addr)
  );

  pt_pte_eval #(.PPN_W(PPN_W)) u_eval (
    .pte      (pte_q),
    .is_write (wr_q),
    .present  (present),
    .ppn      (ppn),
    .writable (writable),
    .need_wb  (need_wb),
    .wb_word  (wb_word)
  );

  always_comb begin
    busy            = (state_q != S_IDLE);
    mem_req         = (state_q == S_RREQ) || (state_q == S_WBACK);
    mem_we          = (state_q == S_WBACK);
    mem_addr        = entry_addr;
    mem_wdata       = wb_word;
    refill_valid    = (state_q == S_REFILL);
    refill_vpn      = vpn_q;
    refill_ppn      = ppn;
    refill_writable = writable;
    fault           = (state_q == S_FAULT);
    fault_vpn       = vpn_q;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (!mem_req && !refill_valid && !fault));

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> (mem_req && !mem_we));

  // R5
  wb_then_refill_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && mem_we) |=> refill_valid);

  // R9
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (refill_valid || fault) |=> !busy);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !refill_valid && !fault) |=> $stable(vpn_q));

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

  localparam int ADDR_W = 32;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              miss_start = 1'b0;
  logic [VPN_W-1:0]  miss_vpn = '0;
  logic              miss_write = 1'b0;
  logic [ADDR_W-1:0] pt_base = '0;
  logic              busy, mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic              mem_rvalid = 1'b0;
  logic [31:0]       mem_rdata = 32'hDEAD_BEEF;
  logic              refill_valid, refill_writable, fault;
  logic [VPN_W-1:0]  refill_vpn, fault_vpn;
  logic [PPN_W-1:0]  refill_ppn;

  always #4 clk = ~clk;

  pt_walker #(.ADDR_W(ADDR_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .miss_vpn(miss_vpn),
    .miss_write(miss_write), .pt_base(pt_base), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .refill_valid(refill_valid),
    .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
    .refill_writable(refill_writable), .fault(fault), .fault_vpn(fault_vpn)
  );

  int n_chk = 0;
  int n_bad = 0;

  // monitor and memory model state
  int cyc = 0, n_rd = 0, n_wr = 0, n_ref = 0, n_flt = 0, n_busy = 0;
  int rise_cyc = -1, rd_cyc = -1, rv_cyc = -1, end_cyc = -1;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
  logic [PPN_W-1:0] got_ppn = '0;
  logic [VPN_W-1:0] got_vpn = '0;
  logic got_wrp = 1'b0;
  logic prev_busy = 1'b0;
  int lat = 0;
  logic [31:0] resp = '0;
  bit pend = 1'b0;
  int cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (busy) begin
      n_busy++;
      if (!prev_busy) rise_cyc = cyc;
    end
    prev_busy = busy;
    if (refill_valid) begin
      n_ref++; end_cyc = cyc;
      got_ppn = refill_ppn; got_vpn = refill_vpn; got_wrp = refill_writable;
    end
    if (fault) begin
      n_flt++; end_cyc = cyc; got_vpn = fault_vpn;
    end
    if (mem_req && mem_we) begin
      n_wr++; wr_addr = mem_addr; wr_data = mem_wdata;
    end
    mem_rvalid = 1'b0;
    mem_rdata  = 32'hDEAD_BEEF;
    if (pend) begin
      if (cnt == 0) begin
        mem_rvalid = 1'b1; mem_rdata = resp; pend = 1'b0; rv_cyc = cyc;
      end else cnt--;
    end
    if (mem_req && !mem_we) begin
      n_rd++; rd_addr = mem_addr; rd_cyc = cyc; pend = 1'b1; cnt = lat;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int b_rd, b_wr, b_ref, b_flt, b_busy;

  task automatic walk(input logic [VPN_W-1:0] vpn, input logic [31:0] base,
                      input logic wr, input logic [31:0] pte, input int l, input bit poke);
    b_rd = n_rd; b_wr = n_wr; b_ref = n_ref; b_flt = n_flt; b_busy = n_busy;
    @(negedge clk);
    lat = l; resp = pte;
    miss_vpn = vpn; pt_base = base; miss_write = wr; miss_start = 1'b1;
    @(negedge clk);
    miss_start = 1'b0; miss_vpn = ~vpn; pt_base = base + 32'h1000; miss_write = ~wr;
    if (poke) begin
      @(negedge clk); miss_start = 1'b1;
      @(negedge clk); miss_start = 1'b0;
    end
    for (int i = 0; i < 200 && (n_ref + n_flt) == (b_ref + b_flt); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 mem_req after reset", 32'(mem_req), 0);
    chk("R1 refill after reset", 32'(refill_valid), 0);
    chk("R1 fault after reset", 32'(fault), 0);
  endtask

  task automatic t_clean_read();
    walk(20'hABCDE, 32'h0010_0000, 1'b0, 32'hB002_1357, 3, 1'b0);
    chk("R2 read address", rd_addr, 32'h0010_0000 + 32'hABCDE * 4);
    chk("R2 read in first busy cycle", 32'(rd_cyc), 32'(rise_cyc));
    chk("R3 single read", 32'(n_rd - b_rd), 1);
    chk("R4 no write", 32'(n_wr - b_wr), 0);
    chk("R4 one refill", 32'(n_ref - b_ref), 1);
    chk("R4 ppn", 32'(got_ppn), 32'h2_1357);
    chk("R4 vpn", 32'(got_vpn), 32'hABCDE);
    chk("R4 refill delay", 32'(end_cyc - rv_cyc), 2);
    chk("R10 writable set", 32'(got_wrp), 1);
    chk("R9 busy length", 32'(n_busy - b_busy), 3 + 4);
    chk("R9 busy released", 32'(busy), 0);
  endtask

  task automatic t_ref_clear();
    walk(20'h00001, 32'h0000_4000, 1'b0, 32'h8000_0042, 0, 1'b0);
    chk("R5 one write", 32'(n_wr - b_wr), 1);
    chk("R5 write address", wr_addr, rd_addr);
    chk("R5 write data", wr_data, 32'hA000_0042);
    chk("R5 refill delay", 32'(end_cyc - rv_cyc), 3);
    chk("R5 refill count", 32'(n_ref - b_ref), 1);
    chk("R10 writable clear", 32'(got_wrp), 0);
    chk("R9 busy length with write", 32'(n_busy - b_busy), 0 + 5);
  endtask

  task automatic t_store_dirty();
    walk(20'hFFFFF, 32'h8000_0000, 1'b1, 32'hB003_FFFF, 5, 1'b0);
    chk("R6 read address top page", rd_addr, 32'h803F_FFFC);
    chk("R6 one write", 32'(n_wr - b_wr), 1);
    chk("R6 dirty set", wr_data, 32'hF003_FFFF);
    chk("R6 refill ppn", 32'(got_ppn), 32'h3_FFFF);
    walk(20'h00010, 32'h0000_0000, 1'b1, 32'h8000_0001, 1, 1'b0);
    chk("R6 dirty and ref set", wr_data, 32'hE000_0001);
    walk(20'h00020, 32'h0000_0000, 1'b1, 32'hF000_0007, 2, 1'b0);
    chk("R6 no write when flags set", 32'(n_wr - b_wr), 0);
    chk("R4 store refill delay", 32'(end_cyc - rv_cyc), 2);
  endtask

  task automatic t_fault();
    walk(20'h12345, 32'h0200_0000, 1'b1, 32'h7FFF_FFFF, 2, 1'b0);
    chk("R7 one fault", 32'(n_flt - b_flt), 1);
    chk("R7 no refill", 32'(n_ref - b_ref), 0);
    chk("R7 no write", 32'(n_wr - b_wr), 0);
    chk("R7 fault vpn", 32'(got_vpn), 32'h12345);
    chk("R7 fault delay", 32'(end_cyc - rv_cyc), 2);
    chk("R9 busy length fault", 32'(n_busy - b_busy), 2 + 4);
  endtask

  task automatic t_busy_ignore();
    walk(20'h0F0F0, 32'h0000_8000, 1'b0, 32'hA000_0123, 4, 1'b1);
    chk("R8 single read", 32'(n_rd - b_rd), 1);
    chk("R8 single refill", 32'(n_ref - b_ref), 1);
    chk("R8 first vpn kept", 32'(got_vpn), 32'h0F0F0);
    chk("R8 idle after", 32'(busy), 0);
  endtask

  initial begin
    t_reset();
    t_clean_read();
    t_ref_clear();
    t_store_dirty();
    t_fault();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule